// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block turns parallel characters into an asynchronous serial frame on a single line. A one-entry holding buffer accepts a write while the shifter is busy with the previous character. The shifter pulls the next character the moment the current frame ends, so back-to-back characters leave no idle gap on the line. The character length, the parity mode and the number of stop bits are chosen on input pins. The bit timing comes from an external enable that pulses once per bit period.

Two flags report progress. `buf_empty` says the holding buffer can take another character. `tx_done` says the line has gone idle after a frame with nothing left to send. Each flag has its own interrupt request, gated by its own enable pin. The done flag stays set until it is cleared, either by a write-one strobe or by the interrupt-service acknowledge.

Top module: `serial_tx_core`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1, `tx_done` is 0, and each interrupt request follows only its enable and its flag.
- R2: A frame is a low start bit, then the data bits LSB first, then the optional parity bit, then high stop bits. A bit changes only at a clock edge where `bit_tick` is sampled high. The start bit appears in the cycle after the shifter takes the character from the buffer.
- R3: `len_code` selects the data length: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits, and 4 to 7 give 9 bits. Bits of `wr_byte` above the selected length have no effect on the line.
- R4: In 9-bit mode the ninth data bit is the value of `ninth_bit` at the write. Later changes to `ninth_bit` do not alter that character.
- R5: `par_mode` 2'b00 or 2'b01 sends no parity bit. 2'b10 sends even parity and 2'b11 sends odd parity, both computed over the data bits actually sent.
- R6: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two.
- R7: A write while `buf_empty` is 1 is taken, and `buf_empty` reads 0 in the next cycle. With the transmitter idle and enabled, the character moves to the shifter one cycle later, `buf_empty` returns to 1, and the start bit shows. A write while `buf_empty` is 0 is ignored.
- R8: When a character waits in the buffer, its start bit follows the last stop bit of the current frame directly, with no idle cycle.
- R9: `tx_done` becomes 1 in the cycle after the final stop bit ends if no character is waiting, and it stays 1 until cleared. It is not set when a waiting character follows directly.
- R10: A pulse on `done_clr` or on `done_ack` clears `tx_done` in the next cycle.
- R11: `irq_empty` is `ie_empty` AND `buf_empty`. `irq_done` is `ie_done` AND `tx_done`.
- R12: While `tx_en` is 0 the line is held high and no frame starts. A buffered character is kept, and it starts in the cycle after `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Character write strobe |
| wr_byte | input | 8 | Low eight data bits of the character |
| ninth_bit | input | 1 | Ninth data bit, captured at the write |
| len_code | input | 3 | Data length select |
| par_mode | input | 2 | Parity select |
| two_stop | input | 1 | Two stop bits when 1 |
| done_clr | input | 1 | Write-one clear of `tx_done` |
| done_ack | input | 1 | Interrupt-service clear of `tx_done` |
| ie_empty | input | 1 | Enable for `irq_empty` |
| ie_done | input | 1 | Enable for `irq_done` |
| txd | output | 1 | Serial line, idle high |
| buf_empty | output | 1 | Holding buffer can accept a write |
| tx_done | output | 1 | Line idle with nothing pending |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Transmit-complete interrupt request |

## Verification
A write lowers `buf_empty` one edge later. On an idle, enabled transmitter, the next edge restores `buf_empty` and drives the start bit, so the bench checks those two cycles one falling edge apart. Each later bit appears on the edge after a sampled tick, so the monitor waits for a falling edge with `bit_tick` high and compares the line at the following falling edge. One tick after the last stop bit, the monitor expects either an immediate start bit or a set `tx_done`, depending on whether a character is queued. Flag clears and the enable release are checked one falling edge after the strobe or the enable change.

// File: rtl/stx_pkg.sv
package stx_pkg;

   // Parity selection as carried on the par_mode pins.
   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_RSVD = 2'b01,
      PAR_EVEN = 2'b10,
      PAR_ODD  = 2'b11
   } par_mode_t;

endpackage

// File: rtl/stx_holding.sv
// One-entry holding buffer between the write port and the shifter.
module stx_holding #(
   parameter int WR_W   = 8,
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WR_W-1:0]   wr_byte,
   input  logic              ninth_bit,
   input  logic              take,
   output logic [DATA_W-1:0] buf_q,
   output logic              full
);

   logic [DATA_W-1:0] wr_word;

   generate
      if (DATA_W > WR_W) begin : g_ext
         assign wr_word = {ninth_bit, wr_byte};
      end else begin : g_plain
         logic unused_ninth;
         assign unused_ninth = ninth_bit;
         assign wr_word = wr_byte[DATA_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         full  <= 1'b0;
      end else begin
         if (take) begin
            full <= 1'b0;
         end
         if (wr_en && !full) begin
            buf_q <= wr_word;
            full  <= 1'b1;
         end
      end
   end

   // R7: an accepted write fills the buffer
   assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !full |=> full);
   // R7: a write into a full buffer leaves its contents untouched
   assert_ignore_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && full |=> $stable(buf_q));
   // the shifter only pulls a held character
   assert_take_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full);

endmodule

// File: rtl/stx_framer.sv
// Builds the line-order bit vector and its length for one character.
module stx_framer
   import stx_pkg::*;
#(
   parameter int DATA_W    = 9,
   parameter int MIN_BITS  = 5,
   parameter int LEN_W     = 3,
   parameter bit PARITY_EN = 1'b1,
   parameter bit STOP2_EN  = 1'b1,
   parameter int FRAME_W   = 13,
   parameter int CNT_W     = 4
) (
   input  logic [DATA_W-1:0]  data,
   input  logic [LEN_W-1:0]   len_code,
   input  logic [1:0]         par_mode,
   input  logic               two_stop,
   output logic [FRAME_W-1:0] frame_vec,
   output logic [CNT_W-1:0]   frame_len
);

   logic [CNT_W-1:0]  nbits;
   logic [DATA_W-1:0] masked;
   logic              acc;
   logic              use_par;
   logic              par_bit;
   logic              stop2;

   always_comb begin
      nbits = CNT_W'(MIN_BITS) + CNT_W'(len_code);
      if (nbits > CNT_W'(DATA_W)) begin
         nbits = CNT_W'(DATA_W);
      end
      for (int i = 0; i < DATA_W; i++) begin
         masked[i] = (CNT_W'(i) < nbits) ? data[i] : 1'b0;
      end
      acc = ^masked;
   end

   generate
      if (PARITY_EN) begin : g_par
         par_mode_t pm;
         assign pm      = par_mode_t'(par_mode);
         assign use_par = (pm == PAR_EVEN) || (pm == PAR_ODD);
         assign par_bit = acc ^ (pm == PAR_ODD);
      end else begin : g_nopar
         logic [2:0] unused_par;
         assign unused_par = {par_mode, acc};
         assign use_par    = 1'b0;
         assign par_bit    = 1'b0;
      end
      if (STOP2_EN) begin : g_stop2
         assign stop2 = two_stop;
      end else begin : g_stop1
         logic unused_stop;
         assign unused_stop = two_stop;
         assign stop2       = 1'b0;
      end
   endgenerate

   always_comb begin
      frame_vec    = '1;
      frame_vec[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (CNT_W'(i) < nbits) begin
            frame_vec[1+i] = masked[i];
         end
      end
      if (use_par) begin
         frame_vec[nbits + CNT_W'(1)] = par_bit;
      end
      frame_len = nbits + CNT_W'(2) + CNT_W'(use_par) + CNT_W'(stop2);
   end

endmodule

// File: rtl/stx_shifter.sv
// Shifts a frame vector onto the line, one bit per tick.
module stx_shifter #(
   parameter int FRAME_W = 13,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               tick,
   input  logic               held,
   input  logic [FRAME_W-1:0] frame_vec,
   input  logic [CNT_W-1:0]   frame_len,
   output logic               take,
   output logic               frame_end,
   output logic               busy,
   output logic               txd
);

   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   left;
   logic               last_edge;

   assign last_edge = enable && busy && tick && (left == CNT_W'(1));
   assign frame_end = last_edge;
   assign take      = enable && held && (!busy || last_edge);
   assign txd       = (enable && busy) ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '1;
         left  <= '0;
         busy  <= 1'b0;
      end else if (!enable) begin
         shreg <= '1;
         left  <= '0;
         busy  <= 1'b0;
      end else if (take) begin
         shreg <= frame_vec;
         left  <= frame_len;
         busy  <= 1'b1;
      end else if (busy && tick) begin
         if (left == CNT_W'(1)) begin
            shreg <= '1;
            left  <= '0;
            busy  <= 1'b0;
         end else begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - CNT_W'(1);
         end
      end
   end

   // R2: every frame opens with a low start bit
   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) && enable |-> !txd);
   // R2: a frame ends only on a tick, or by disabling
   assert_end_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick) || !$past(enable));
   // R12: a disabled transmitter starts nothing
   assert_no_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !busy);
   assert_count_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> left != '0);

endmodule

// File: rtl/stx_flags.sv
// Buffer-empty and transmit-complete flags with their interrupt gating.
module stx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_end,
   input  logic take,
   input  logic held,
   input  logic clr_wr,
   input  logic clr_ack,
   input  logic ie_empty,
   input  logic ie_done,
   output logic buf_empty,
   output logic tx_done,
   output logic irq_empty,
   output logic irq_done
);

   logic set_done;

   assign set_done  = frame_end && !take;
   assign buf_empty = !held;
   assign irq_empty = ie_empty && buf_empty;
   assign irq_done  = ie_done && tx_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_done <= 1'b0;
      end else if (set_done) begin
         tx_done <= 1'b1;
      end else if (clr_wr || clr_ack) begin
         tx_done <= 1'b0;
      end
   end

   // R9: the flag rises only at the end of a frame
   assert_done_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> $past(frame_end));
   // R9: the flag holds until cleared
   assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done && !clr_wr && !clr_ack |=> tx_done);
   // R10: either clear strobe drops the flag
   assert_done_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr || clr_ack) && !frame_end |=> !tx_done);

endmodule

// File: rtl/serial_tx_core.sv
// Buffered asynchronous serial transmitter.
module serial_tx_core
   import stx_pkg::*;
#(
   parameter int WR_W      = 8,
   parameter int MIN_BITS  = 5,
   parameter int MAX_BITS  = 9,
   parameter int LEN_W     = 3,
   parameter bit PARITY_EN = 1'b1,
   parameter bit STOP2_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             bit_tick,
   input  logic             wr_en,
   input  logic [WR_W-1:0]  wr_byte,
   input  logic             ninth_bit,
   input  logic [LEN_W-1:0] len_code,
   input  logic [1:0]       par_mode,
   input  logic             two_stop,
   input  logic             done_clr,
   input  logic             done_ack,
   input  logic             ie_empty,
   input  logic             ie_done,
   output logic             txd,
   output logic             buf_empty,
   output logic             tx_done,
   output logic             irq_empty,
   output logic             irq_done
);

   localparam int FRAME_W = 1 + MAX_BITS + int'(PARITY_EN) + 1 + int'(STOP2_EN);
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (MIN_BITS < 1 || MAX_BITS < MIN_BITS) begin : g_bad_len
         $error("serial_tx_core: data length range is empty");
      end
      if (MAX_BITS > WR_W + 1) begin : g_bad_width
         $error("serial_tx_core: at most one data bit may come from ninth_bit");
      end
      if (MIN_BITS + (1 << LEN_W) - 1 >= (1 << CNT_W)) begin : g_bad_code
         $error("serial_tx_core: len_code range overflows the bit counter");
      end
   endgenerate

   logic [MAX_BITS-1:0] buf_q;
   logic                held;
   logic                take;
   logic                frame_end;
   logic                busy;
   logic [FRAME_W-1:0]  frame_vec;
   logic [CNT_W-1:0]    frame_len;

   stx_holding #(
      .WR_W   (WR_W),
      .DATA_W (MAX_BITS)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_byte   (wr_byte),
      .ninth_bit (ninth_bit),
      .take      (take),
      .buf_q     (buf_q),
      .full      (held)
   );

   stx_framer #(
      .DATA_W    (MAX_BITS),
      .MIN_BITS  (MIN_BITS),
      .LEN_W     (LEN_W),
      .PARITY_EN (PARITY_EN),
      .STOP2_EN  (STOP2_EN),
      .FRAME_W   (FRAME_W),
      .CNT_W     (CNT_W)
   ) u_frame (
      .data      (buf_q),
      .len_code  (len_code),
      .par_mode  (par_mode),
      .two_stop  (two_stop),
      .frame_vec (frame_vec),
      .frame_len (frame_len)
   );

   stx_shifter #(
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (tx_en),
      .tick      (bit_tick),
      .held      (held),
      .frame_vec (frame_vec),
      .frame_len (frame_len),
      .take      (take),
      .frame_end (frame_end),
      .busy      (busy),
      .txd       (txd)
   );

   stx_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .take      (take),
      .held      (held),
      .clr_wr    (done_clr),
      .clr_ack   (done_ack),
      .ie_empty  (ie_empty),
      .ie_done   (ie_done),
      .buf_empty (buf_empty),
      .tx_done   (tx_done),
      .irq_empty (irq_empty),
      .irq_done  (irq_done)
   );

   // R8: a queued character follows the last stop bit directly
   assert_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end && held |=> busy && !txd);
   // R12: the line stays high while disabled
   assert_line_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en && !$past(tx_en) |-> txd);

endmodule

// File: tb/test_serial_tx_core.sv
`timescale 1ns/1ps
module test_serial_tx_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b1;
   logic       bit_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_byte = '0;
   logic       ninth_bit = 1'b0;
   logic [2:0] len_code = 3'd3;
   logic [1:0] par_mode = 2'b00;
   logic       two_stop = 1'b0;
   logic       done_clr = 1'b0;
   logic       done_ack = 1'b0;
   logic       ie_empty = 1'b0;
   logic       ie_done = 1'b0;
   logic       txd, buf_empty, tx_done, irq_empty, irq_done;

   int checks = 0;
   int fails  = 0;
   logic [16:0] exp_q[$];

   always #10 clk = ~clk;

   serial_tx_core i_serial_tx_core (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
      .wr_en(wr_en), .wr_byte(wr_byte), .ninth_bit(ninth_bit),
      .len_code(len_code), .par_mode(par_mode), .two_stop(two_stop),
      .done_clr(done_clr), .done_ack(done_ack), .ie_empty(ie_empty),
      .ie_done(ie_done), .txd(txd), .buf_empty(buf_empty),
      .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // One-cycle tick every five clocks, changed just after the rising edge.
   initial begin
      int tcnt = 0;
      forever begin
         @(posedge clk);
         #2;
         tcnt = (tcnt + 1) % 5;
         bit_tick = (tcnt == 0);
      end
   end

   // Expected line sequence {length, bits in line order} from the requirements.
   function automatic logic [16:0] expect_frame(input logic [8:0] d, input int code,
                                                input logic [1:0] pm, input logic st);
      logic [12:0] v = '1;
      logic        p = 1'b0;
      int nb = (5 + code > 9) ? 9 : 5 + code;
      int idx;
      v[0] = 1'b0;
      for (int i = 0; i < nb; i++) begin
         v[1+i] = d[i];
         p ^= d[i];
      end
      idx = 1 + nb;
      if (pm[1]) begin
         v[idx] = pm[0] ? ~p : p;
         idx++;
      end
      idx = idx + 1 + (st ? 1 : 0);
      return {4'(idx), v};
   endfunction

   task automatic write_char(input logic [7:0] d, input logic nb9);
      logic ok;
      @(negedge clk);
      ok        = buf_empty;
      wr_byte   = d;
      ninth_bit = nb9;
      wr_en     = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      if (ok) exp_q.push_back(expect_frame({nb9, d}, int'(len_code), par_mode, two_stop));
   endtask

   task automatic wait_bit_tick();
      while (!bit_tick) @(negedge clk);
   endtask

   // Monitor: decodes frames from the line and compares with the scoreboard.
   initial begin
      wait (rst_n);
      @(negedge clk);
      forever begin
         logic [16:0] e;
         logic [12:0] got;
         int n;
         while (txd !== 1'b0) @(negedge clk);
         if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected frame", 0, 1);
            e = '1;
         end else begin
            e = exp_q.pop_front();
         end
         n = int'(e[16:13]);
         got = '1;
         got[0] = txd;
         for (int i = 1; i < n; i++) begin
            wait_bit_tick();
            @(negedge clk);
            got[i] = txd;
         end
         // R2 R3 R4 R5 R6: line bits in order
         check((got & ((13'd1 << n) - 13'd1)) == (e[12:0] & ((13'd1 << n) - 13'd1)),
               "R2", "frame bits", int'(got), int'(e[12:0]));
         wait_bit_tick();
         @(negedge clk);
         if (exp_q.size() == 0) begin
            check(tx_done === 1'b1 && txd === 1'b1, "R9", "done after last stop",
                  int'({tx_done, txd}), 3);
         end else begin
            check(txd === 1'b0 && tx_done === 1'b0, "R8", "next start without gap",
                  int'({tx_done, txd}), 0);
         end
      end
   end

   task automatic wait_done();
      int t = 0;
      while (tx_done !== 1'b1 && t < 3000) begin
         @(negedge clk);
         t++;
      end
      check(tx_done === 1'b1, "R9", "done reached", int'(tx_done), 1);
      repeat (3) @(negedge clk);
   endtask

   task automatic clear_done(input bit use_ack);
      @(negedge clk);
      if (use_ack) done_ack = 1'b1; else done_clr = 1'b1;
      @(negedge clk);
      done_ack = 1'b0;
      done_clr = 1'b0;
      check(tx_done === 1'b0, "R10", use_ack ? "ack clear" : "write-one clear",
            int'(tx_done), 0);
   endtask

   initial begin
      #3000000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(txd === 1'b1, "R1", "idle line", int'(txd), 1);
      check(buf_empty === 1'b1, "R1", "buffer empty", int'(buf_empty), 1);
      check(tx_done === 1'b0 && irq_done === 1'b0, "R1", "done clear",
            int'({tx_done, irq_done}), 0);
      check(irq_empty === 1'b0, "R1", "empty irq masked", int'(irq_empty), 0);
      ie_empty = 1'b1;
      @(negedge clk);
      check(irq_empty === 1'b1, "R11", "empty irq enabled", int'(irq_empty), 1);

      // R7 timing and 8N1 frame
      len_code = 3'd3; par_mode = 2'b00; two_stop = 1'b0;
      write_char(8'hA5, 1'b0);
      check(buf_empty === 1'b0, "R7", "buffer full after write", int'(buf_empty), 0);
      check(irq_empty === 1'b0, "R11", "empty irq low while full", int'(irq_empty), 0);
      @(negedge clk);
      check(buf_empty === 1'b1 && txd === 1'b0, "R7", "transfer and start bit",
            int'({buf_empty, txd}), 2);
      wait_done();
      check(irq_done === 1'b0, "R11", "done irq masked", int'(irq_done), 0);
      ie_done = 1'b1;
      @(negedge clk);
      check(irq_done === 1'b1, "R11", "done irq enabled", int'(irq_done), 1);
      clear_done(1'b0);
      check(irq_done === 1'b0, "R11", "done irq drops with flag", int'(irq_done), 0);

      // R3 R5: five bits, even parity, upper bits ignored
      len_code = 3'd0; par_mode = 2'b10;
      write_char(8'hFF, 1'b0);
      wait_done();
      clear_done(1'b1);
      write_char(8'hE6, 1'b0);
      wait_done();
      clear_done(1'b1);

      // R5 R6: seven bits, odd parity, two stop bits
      len_code = 3'd2; par_mode = 2'b11; two_stop = 1'b1;
      write_char(8'h35, 1'b0);
      wait_done();
      clear_done(1'b0);

      // R5: reserved code sends no parity; six bits
      len_code = 3'd1; par_mode = 2'b01; two_stop = 1'b0;
      write_char(8'h2B, 1'b0);
      wait_done();
      clear_done(1'b0);

      // R4: nine bits, ninth bit captured at the write
      len_code = 3'd4; par_mode = 2'b10;
      write_char(8'h0F, 1'b1);
      ninth_bit = 1'b0;
      wait_done();
      clear_done(1'b0);
      len_code = 3'd7;
      write_char(8'h80, 1'b0);
      ninth_bit = 1'b1;
      wait_done();
      clear_done(1'b0);

      // R8 R7: back-to-back, third write ignored while full
      len_code = 3'd3; par_mode = 2'b00;
      write_char(8'h3C, 1'b0);
      @(negedge clk);
      write_char(8'hC3, 1'b0);
      check(buf_empty === 1'b0, "R7", "second char held", int'(buf_empty), 0);
      write_char(8'h99, 1'b0);
      wait_done();
      clear_done(1'b0);

      // R12: disabled transmitter keeps data and holds the line
      tx_en = 1'b0;
      write_char(8'h5A, 1'b0);
      begin
         bit ok = 1'b1;
         for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (txd !== 1'b1 || buf_empty !== 1'b0) ok = 1'b0;
         end
         check(ok, "R12", "line high and data kept while disabled",
               int'({txd, buf_empty}), 2);
      end
      write_char(8'h11, 1'b0);
      @(negedge clk);
      tx_en = 1'b1;
      @(negedge clk);
      check(txd === 1'b0 && buf_empty === 1'b1, "R12", "start after enable",
            int'({txd, buf_empty}), 1);
      wait_done();
      check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

      report();
      $finish;
   end

endmodule